// File: doc/BRIEF.md
# Ethernet MII Frame Transmitter with Inline FCS

This block sends one fixed-size Ethernet frame over a 4-bit MII transmit interface each time it is started. It drives the preamble and start-of-frame delimiter, then the destination and source MAC addresses, the length/type word, a fixed number of payload octets and finally the frame check sequence. The payload sits in a small on-chip buffer. Software or a neighbouring block fills this buffer through a simple write port before it pulses `start`.

A CRC-32 engine consumes the same nibbles that go out on the wire, four bits per clock, in wire bit order. The FCS octets are then produced from that CRC. Each octet is complemented and bit-reversed, and the octets are taken from the most significant one down, so the ordinary low-nibble-first path sends them with no second shifter. After each frame the block holds the line idle for an interframe gap before it accepts another start.

Top module: `mii_frame_tx`

## Requirements
- R1: After reset, `txd` is 0, `tx_en` is 0 and `done` is 0, and the block waits for `start`.
- R2: A `start` sampled high while idle makes `tx_en` rise two clocks later. The first 14 nibbles are 0x5 (seven 0x55 octets), followed by nibbles 0x5 then 0xD (octet 0xD5).
- R3: Every octet goes out low nibble first. The address octets go most significant octet first: `dst_mac[47:40]` first, then `src_mac[47:40]` first. The length/type word sends `len_type[15:8]` before `len_type[7:0]`. Addresses and length/type are captured when `start` is accepted.
- R4: PAYLOAD_OCTETS payload octets follow the length/type word, in buffer address order 0 upward, as written through `pay_wr_en`/`pay_wr_addr`/`pay_wr_data`.
- R5: The CRC uses the CRC-32 polynomial 0x04C11DB7 with the register preset to all ones. It covers the destination address through the last payload octet and nothing else.
- R6: The four FCS octets are each CRC octet complemented and bit-reversed, taken CRC bits 31..24 first. For destination 0D×6, source 0C×6, type 0x8808 and payload 00 01 followed by 44×77, the FCS on the wire is E5 5C 0B F8.
- R7: `tx_en` falls in the clock right after the last FCS nibble. `txd` is 0 whenever `tx_en` is 0. `done` is high for exactly that one first idle clock.
- R8: A `start` pulse while a frame is being sent is ignored.
- R9: A `start` is ignored from the `done` clock through the following IFG_NIBBLES-2 clocks, and is accepted IFG_NIBBLES-1 clocks after `done`. The line therefore stays idle for at least IFG_NIBBLES+1 clocks between frames.
- R10: Each frame holds `tx_en` high for exactly 2*(26+PAYLOAD_OCTETS) consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send one frame |
| dst_mac | input | 48 | Destination address, first octet in [47:40] |
| src_mac | input | 48 | Source address, first octet in [47:40] |
| len_type | input | 16 | Length/type word, [15:8] sent first |
| pay_wr_en | input | 1 | Payload buffer write strobe |
| pay_wr_addr | input | PAY_AW | Payload buffer write address |
| pay_wr_data | input | 8 | Payload buffer write octet |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |
| done | output | 1 | One-clock pulse at the first idle clock after a frame |

## Verification
The hardest situation to reach is a start that lands at the exact edge of the interframe gap. One clock too early must be ignored, and the next clock must launch a frame. The stimulus waits for `done`, pulses start once early in the gap, and then holds start across the last blocked clock and the first accepted clock. The bench then measures the idle run on `tx_en`. A second hard case is proving the FCS bit ordering against a known frame. The bench sends the example frame and rebuilds the four FCS octets from the captured nibbles, while a byte-wise reflected CRC model checks every other frame.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  localparam logic [7:0]  PREAMBLE_OCTET = 8'h55;
  localparam logic [7:0]  SFD_OCTET      = 8'hD5;
  localparam logic [31:0] CRC32_POLY     = 32'h04C11DB7;
  localparam int          PRE_OCTETS     = 7;
  localparam int          HDR_OCTETS     = 14;
  localparam int          FCS_OCTETS     = 4;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/mii_payload_buf.sv
module mii_payload_buf #(
  parameter int DEPTH = 46,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mii_crc32_nib.sv
module mii_crc32_nib
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic [31:0] crc_q
);

  logic [31:0] crc_nx;

  // nib[0] is the first bit on the wire, so it is folded in first
  always_comb begin
    logic [31:0] c;
    logic        fb;
    c = crc_q;
    for (int i = 0; i < 4; i++) begin
      fb = c[31] ^ nib[i];
      c  = {c[30:0], 1'b0} ^ (fb ? CRC32_POLY : 32'h0);
    end
    crc_nx = c;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '1;
    else if (en)      crc_q <= crc_nx;
  end

endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int LAST_NIB = 143,
  parameter int IFG      = 24,
  parameter int NW       = 8,
  parameter int GW       = $clog2(IFG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output tx_state_e     state,
  output logic [NW-1:0] nib_idx,
  output logic          launch
);

  logic [GW-1:0] gap_cnt;

  assign launch = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nib_idx <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SEND;
          nib_idx <= '0;
        end
        ST_SEND: if (nib_idx == NW'(LAST_NIB)) begin
          state   <= ST_GAP;
          gap_cnt <= '0;
        end else begin
          nib_idx <= nib_idx + 1'b1;
        end
        ST_GAP: if (gap_cnt == GW'(IFG - 1)) state <= ST_IDLE;
                else gap_cnt <= gap_cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_GAP_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    state == ST_GAP |=> state != ST_SEND); // R9

  AST_SEND_INDEX_BOUND: assert property (@(posedge clk) disable iff (rst)
    state == ST_SEND |-> nib_idx <= NW'(LAST_NIB)); // R10

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int PAYLOAD_OCTETS = 46,
  parameter int IFG_NIBBLES    = 24,
  parameter int PAY_AW         = $clog2(PAYLOAD_OCTETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [47:0]       dst_mac,
  input  logic [47:0]       src_mac,
  input  logic [15:0]       len_type,
  input  logic              pay_wr_en,
  input  logic [PAY_AW-1:0] pay_wr_addr,
  input  logic [7:0]        pay_wr_data,
  output logic [3:0]        txd,
  output logic              tx_en,
  output logic              done
);

  localparam int HDR_START    = PRE_OCTETS + 1;
  localparam int PAY_START    = HDR_START + HDR_OCTETS;
  localparam int FCS_START    = PAY_START + PAYLOAD_OCTETS;
  localparam int FRAME_OCTETS = FCS_START + FCS_OCTETS;
  localparam int FRAME_NIBS   = 2 * FRAME_OCTETS;
  localparam int NW           = $clog2(FRAME_NIBS + 1);

  tx_state_e         state;
  logic [NW-1:0]     nib_idx;
  logic              launch;
  logic [111:0]      hdr_q;
  logic [PAY_AW-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic [31:0]       crc_q;
  logic [7:0]        octet;
  logic [3:0]        nib;
  logic              crc_en;
  logic              send_now;

  mii_tx_seq #(
    .LAST_NIB (FRAME_NIBS - 1),
    .IFG      (IFG_NIBBLES),
    .NW       (NW)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .state   (state),
    .nib_idx (nib_idx),
    .launch  (launch)
  );

  mii_payload_buf #(
    .DEPTH (PAYLOAD_OCTETS),
    .AW    (PAY_AW),
    .DW    (8)
  ) u_buf (
    .clk     (clk),
    .wr_en   (pay_wr_en),
    .wr_addr (pay_wr_addr),
    .wr_data (pay_wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  mii_crc32_nib u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear (!send_now),
    .en    (crc_en),
    .nib   (nib),
    .crc_q (crc_q)
  );

  assign send_now = (state == ST_SEND);

  // header captured at launch, first wire octet in the top bits
  always_ff @(posedge clk) begin
    if (rst)         hdr_q <= '0;
    else if (launch) hdr_q <= {dst_mac, src_mac, len_type};
  end

  // octet on the wire for the current nibble index
  always_comb begin
    int oi;
    oi = int'(nib_idx) / 2;
    if (oi < PRE_OCTETS)       octet = PREAMBLE_OCTET;
    else if (oi < HDR_START)   octet = SFD_OCTET;
    else if (oi < PAY_START)   octet = hdr_q[8*(PAY_START-1-oi) +: 8];
    else if (oi < FCS_START)   octet = rd_data;
    else                       octet = rev8(~crc_q[8*(FCS_START+3-oi) +: 8]);
    nib    = nib_idx[0] ? octet[7:4] : octet[3:0];
    crc_en = send_now && (oi >= HDR_START) && (oi < FCS_START);
  end

  // buffer read runs one nibble ahead so each payload octet is ready for both nibbles
  always_comb begin
    int noi;
    noi = (int'(nib_idx) + 1) / 2;
    if (noi >= PAY_START && noi < FCS_START) rd_addr = PAY_AW'(noi - PAY_START);
    else                                     rd_addr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd   <= '0;
      tx_en <= 1'b0;
      done  <= 1'b0;
    end else begin
      txd   <= send_now ? nib : 4'h0;
      tx_en <= send_now;
      done  <= tx_en && !send_now;
    end
  end

  AST_IDLE_TXD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> txd == 4'h0); // R7

  AST_FIRST_NIB_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> txd == 4'h5); // R2

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> !tx_en && $past(tx_en)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

endmodule

// File: tb/tb_mii_frame_tx.sv
module tb_mii_frame_tx;

  localparam int N          = 46;
  localparam int IFG        = 24;
  localparam int AW         = $clog2(N);
  localparam int FRAME_NIBS = 2 * (26 + N);

  logic          clk = 1'b0;
  logic          rst, start, pay_wr_en;
  logic [47:0]   dst, src;
  logic [15:0]   lt;
  logic [AW-1:0] wa;
  logic [7:0]    wd;
  logic [3:0]    txd;
  logic          tx_en, done;

  always #5 clk = ~clk;

  mii_frame_tx #(.PAYLOAD_OCTETS(N), .IFG_NIBBLES(IFG)) dut (
    .clk(clk), .rst(rst), .start(start), .dst_mac(dst), .src_mac(src),
    .len_type(lt), .pay_wr_en(pay_wr_en), .pay_wr_addr(wa), .pay_wr_data(wd),
    .txd(txd), .tx_en(tx_en), .done(done)
  );

  typedef struct {bit en; bit [3:0] d; bit dn; int rq;} exp_t;

  exp_t       exp_q[$];
  exp_t       cur;
  int         blk;
  logic [7:0] pay_m [N];
  logic [7:0] bq[$];
  logic [7:0] cov[$];
  logic [31:0] fw;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic check(bit ok, string rq, string what, longint act, longint ex);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, ex);
    end
  endtask

  // byte-wise reflected CRC-32; result bytes little-endian are the FCS wire octets
  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
    logic [31:0] r = 32'hFFFFFFFF;
    foreach (q[i]) begin
      r ^= {24'h0, q[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return ~r;
  endfunction

  // reference model: one expected output record per clock
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      cur = '{en:0, d:4'h0, dn:0, rq:1};  // R1
      blk = 0;
    end else begin
      bit acc;
      acc = start && (exp_q.size() == 0) && (blk == 0);  // R8 R9
      if (blk > 0) blk--;
      if (acc) begin
        bq.delete(); cov.delete();
        for (int i = 0; i < 7; i++) bq.push_back(8'h55);
        bq.push_back(8'hD5);
        for (int i = 5; i >= 0; i--) cov.push_back(dst[8*i +: 8]);
        for (int i = 5; i >= 0; i--) cov.push_back(src[8*i +: 8]);
        cov.push_back(lt[15:8]); cov.push_back(lt[7:0]);
        for (int i = 0; i < N; i++) cov.push_back(pay_m[i]);
        fw = ref_fcs(cov);
        foreach (cov[i]) bq.push_back(cov[i]);
        for (int i = 0; i < 4; i++) bq.push_back(fw[8*i +: 8]);
        exp_q.push_back('{en:0, d:4'h0, dn:0, rq:7});
        foreach (bq[p]) begin
          int rq;
          if (p < 8)           rq = 2;  // R2 preamble and SFD
          else if (p < 22)     rq = 3;  // R3 header
          else if (p < 22 + N) rq = 4;  // R4 payload
          else                 rq = 6;  // R6 FCS
          exp_q.push_back('{en:1, d:bq[p][3:0], dn:0, rq:rq});
          exp_q.push_back('{en:1, d:bq[p][7:4], dn:0, rq:rq});
        end
        exp_q.push_back('{en:0, d:4'h0, dn:1, rq:7});  // R7
      end
      if (exp_q.size() > 0) cur = exp_q.pop_front();
      else                  cur = '{en:0, d:4'h0, dn:0, rq:7};
      if (cur.dn) blk = IFG - 1;
    end
  end

  // monitor: compare every clock, capture wire nibbles, measure runs
  logic [3:0] wire_q[$];
  bit prev_en = 0, saw_frame = 0;
  int rises = 0, dones = 0, en_run = 0, low_run = 0, last_len = 0, last_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check(txd == cur.d && tx_en == cur.en && done == cur.dn,
            $sformatf("R%0d", cur.rq), "txd/tx_en/done",
            {txd, tx_en, done}, {cur.d, cur.en, cur.dn});
      if (tx_en && !prev_en) begin
        rises++;
        wire_q.delete();
        if (saw_frame) last_gap = low_run;
        saw_frame = 1;
      end
      if (!tx_en && prev_en) begin
        last_len = en_run;
        en_run = 0;
      end
      if (tx_en) begin
        wire_q.push_back(txd);
        en_run++;
        low_run = 0;
      end else low_run++;
      if (done) dones++;
      prev_en = tx_en;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    pay_wr_en = 1; wa = AW'(a); wd = d; pay_m[a] = d;
    @(negedge clk);
    pay_wr_en = 0;
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    rst = 1; start = 0; pay_wr_en = 0; wa = '0; wd = '0;
    dst = '0; src = '0; lt = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(txd == 4'h0 && tx_en == 1'b0 && done == 1'b0, "R1", "reset outputs",
          {txd, tx_en, done}, 0);

    // frame 1: known example frame
    dst = 48'h0D0D0D0D0D0D; src = 48'h0C0C0C0C0C0C; lt = 16'h8808;
    wr(0, 8'h00); wr(1, 8'h01);
    for (int i = 2; i < N; i++) wr(i, 8'h77);
    pulse_start();
    wait_done();
    @(negedge clk);
    begin
      logic [31:0] got;
      for (int k = 0; k < 4; k++)
        got[31-8*k -: 8] = {wire_q[FRAME_NIBS-8+2*k+1], wire_q[FRAME_NIBS-8+2*k]};
      check(got == 32'hE55C0BF8, "R5 R6", "example FCS octets", got, 32'hE55C0BF8);
    end
    check(last_len == FRAME_NIBS, "R10", "tx_en run length", last_len, FRAME_NIBS);
    check(dones == 1, "R7", "done pulses", dones, 1);
    repeat (IFG + 2) @(negedge clk);

    // frame 2: other header and payload, plus a start in mid-frame
    dst = 48'h0123456789AB; src = 48'hFEDCBA987654; lt = 16'h0040;
    for (int i = 0; i < N; i++) wr(i, 8'(i * 37 + 3));
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    dst = 48'hFFFFFFFFFFFF;   // changed after launch: must not alter this frame (R3)
    wait_done();
    @(negedge clk);
    check(rises == 2, "R8", "frames started", rises, 2);
    check(last_len == FRAME_NIBS, "R10", "tx_en run length", last_len, FRAME_NIBS);

    // frame 3: starts inside the gap, the last one held across the boundary
    dst = 48'hA1B2C3D4E5F6; src = 48'h102030405060; lt = 16'hBEEF;
    repeat (2) @(negedge clk);          // done was at d, now at d+3
    pulse_start();                       // start in cycle d+3, ignored
    repeat (IFG - 2 - 4) @(negedge clk); // now at d+IFG-2
    start = 1;                           // ignored in d+IFG-2, accepted in d+IFG-1
    @(negedge clk);
    @(negedge clk);
    start = 0;
    wait_done();
    @(negedge clk);
    check(rises == 3, "R9", "frames started", rises, 3);
    check(last_gap == IFG + 1, "R9", "idle clocks between frames", last_gap, IFG + 1);
    check(dones == 3, "R7", "done pulses", dones, 3);
    repeat (5) @(negedge clk);
    check(tx_en == 1'b0 && txd == 4'h0, "R7", "idle after frame", {txd, tx_en}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule